// File: doc/BRIEF.md
# Command-Driven Nibble I/O Controller

This block is an I/O engine that shares a sixteen-entry, four-bit-wide scratch memory with a host processor. The host fills the memory with a command code and its arguments, then pulses a run strobe. The controller carries out the command on its own. Depending on the code it can sample four 4-bit input ports, drive two 4-bit output ports, latch coin/credit ratio settings for downstream logic, or compute a start-up checksum. It can also run a two-phase scan of a multiplexed switch matrix. Results are left in the memory, where the host reads them back.

Nibble 8 holds the command code and nibbles 9 to 15 hold its arguments. Commands write their results into nibbles 0 to 7. The scan command drives output port A low, samples all four inputs into the even result nibbles, drives port A to 1 and samples again into the odd nibbles. It waits a settling interval before each sample, so an external multiplexer steered by port A bit 0 has time to switch. A separate hold line parks the sequencer and returns the coinage settings to their defaults. The host can see the state of that line.

Top module: `nibble_io_ctrl`

## Requirements
- R1: After `rst_ni` is asserted, every nibble reads 0, both output ports are 0, the four coinage outputs equal `COIN_DEF` (1), and `busy_o`, `done_o` and `hold_stat_o` are 0. The reset takes effect without a clock edge.
- R2: A host write stores only `host_wdata_i[3:0]` into nibble `host_addr_i`. A host read returns `host_rdata_o = {4'hF, nibble}`, combinationally from `host_addr_i`.
- R3: A `run_i` high at a clock edge while the sequencer is idle captures the code in nibble 8. `busy_o` is high from that edge until the command ends. The engine writes the memory only while busy. `run_i` is ignored while busy.
- R4: Code 1 writes the bitwise inverse of ports A, B, C, D into nibbles 0, 1, 2, 3. It sets `out_a_o` from nibble 9 and `out_b_o` from nibble 10.
- R5: Code 2 loads the slot-0 coins-per-credit output from nibble 9 and the slot-0 credits-per-coin output from nibble 10. It loads the slot-1 coins-per-credit output from nibble 11 and the slot-1 credits-per-coin output from nibble 12.
- R6: Code 8 adds nibbles 9 to 15 as an 8-bit sum. It writes sum[7:4] into nibble 0 and sum[3:0] into nibble 1.
- R7: Code 9 sets `out_a_o` to 0, then writes the inverted ports A, B, C, D into nibbles 0, 2, 4, 6. It then sets `out_a_o` to 4'h1 and writes the inverted ports into nibbles 1, 3, 5, 7.
- R8: Each code 9 sample is taken on the clock edge that comes `SETTLE_CYC` (at least 2) edges after the edge that updated `out_a_o`.
- R9: Code 7 writes 4'hE into nibble 2 and 4'h6 into nibble 7, and leaves the other nibbles unchanged.
- R10: Any other code (0, 3 to 6, 10 to 15) changes no nibble, no output port and no coinage output.
- R11: `done_o` is a one-cycle pulse. It rises on the edge where the command's last result lands: one edge after the capture edge, or 1+2·`SETTLE_CYC` edges after it for code 9. It also pulses for unknown codes.
- R12: While `hold_i` is high, the coinage outputs return to `COIN_DEF` on the next edge and the sequencer stays idle, ignoring `run_i`. `hold_stat_o` shows `hold_i` one cycle later. Host access is unaffected.
- R13: If the engine and the host write the same nibble on the same edge, the engine's value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hold_i | input | 1 | Synchronous hold: parks the sequencer and restores the coinage defaults |
| hold_stat_o | output | 1 | Registered copy of `hold_i` for the host |
| host_we_i | input | 1 | Host write enable |
| host_addr_i | input | 4 | Host nibble address |
| host_wdata_i | input | 8 | Host write data; only bits 3:0 are kept |
| host_rdata_o | output | 8 | Host read data, upper nibble forced to 4'hF |
| run_i | input | 1 | Start strobe |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| in_a_i | input | 4 | Input port A |
| in_b_i | input | 4 | Input port B |
| in_c_i | input | 4 | Input port C |
| in_d_i | input | 4 | Input port D |
| out_a_o | output | 4 | Output port A (bit 0 steers the external scan multiplexer) |
| out_b_o | output | 4 | Output port B |
| cfg_coins0_o | output | 4 | Slot-0 coins per credit |
| cfg_creds0_o | output | 4 | Slot-0 credits per coin |
| cfg_coins1_o | output | 4 | Slot-1 coins per credit |
| cfg_creds1_o | output | 4 | Slot-1 credits per coin |

## Verification
A wrong command code captured or a stuck sequencer state shows up at the ports within one command. The `done_o` pulse arrives at the wrong edge, or the memory read-back differs in specific result nibbles. A scan that samples one edge early leaves the wrong multiplexer phase in the even or odd nibbles. This shows only when the external selector lags port A, which the bench models with a one-register delay. A wrong engine/host priority or a coinage register that ignores the hold line shows on the very next read of the affected nibble or output.

// File: rtl/nio_pkg.sv
package nio_pkg;
  localparam int NIB_W  = 4;
  localparam int HOST_W = 8;
  localparam int DEPTH  = 16;
  localparam int AW     = $clog2(DEPTH);
  localparam int NPORT  = 4;
  localparam int ADR_CMD = 8;
  localparam int ADR_ARG = 9;
  localparam int NARG    = DEPTH - ADR_ARG;
  localparam int SUM_W   = 2 * NIB_W;

  typedef logic [NIB_W-1:0] nib_t;

  localparam nib_t CMD_READ_SW  = 4'd1;
  localparam nib_t CMD_COIN_CFG = 4'd2;
  localparam nib_t CMD_PATTERN  = 4'd7;
  localparam nib_t CMD_CHKSUM   = 4'd8;
  localparam nib_t CMD_SCAN2    = 4'd9;

  localparam int   PAT_ADR_LO = 2;
  localparam int   PAT_ADR_HI = 7;
  localparam nib_t PAT_LO     = 4'hE;
  localparam nib_t PAT_HI     = 4'h6;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EXEC,
    ST_SC0,
    ST_SC1
  } seq_st_t;

  typedef struct packed {
    nib_t coins0;
    nib_t creds0;
    nib_t coins1;
    nib_t creds1;
  } coin_cfg_t;
endpackage

// File: rtl/nio_ram.sv
module nio_ram
  import nio_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         host_we_i,
  input  logic [AW-1:0]                host_addr_i,
  input  nib_t                         host_wdata_i,
  input  logic [DEPTH-1:0]             eng_we_i,
  input  logic [DEPTH-1:0][NIB_W-1:0]  eng_wdata_i,
  output logic [DEPTH-1:0][NIB_W-1:0]  mem_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_nib
    // engine write has priority over a colliding host write
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mem_o[i] <= '0;
      else if (eng_we_i[i])
        mem_o[i] <= eng_wdata_i[i];
      else if (host_we_i && host_addr_i == AW'(i))
        mem_o[i] <= host_wdata_i;
    end
  end
endmodule

// File: rtl/nio_chksum.sv
module nio_chksum
  import nio_pkg::*;
(
  input  logic [NARG-1:0][NIB_W-1:0] arg_i,
  output logic [SUM_W-1:0]           sum_o
);
  always_comb begin
    sum_o = '0;
    for (int i = 0; i < NARG; i++)
      sum_o = sum_o + SUM_W'(arg_i[i]);
  end
endmodule

// File: rtl/nio_coin_cfg.sv
module nio_coin_cfg
  import nio_pkg::*;
#(
  parameter int COIN_DEF = 1
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      hold_i,
  input  logic      load_i,
  input  coin_cfg_t cfg_i,
  output coin_cfg_t cfg_o
);
  localparam nib_t DEF = NIB_W'(COIN_DEF);
  localparam coin_cfg_t CFG_DEF = '{coins0: DEF, creds0: DEF, coins1: DEF, creds1: DEF};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_o <= CFG_DEF;
    else if (hold_i) cfg_o <= CFG_DEF;
    else if (load_i) cfg_o <= cfg_i;
  end
endmodule

// File: rtl/nio_seq.sv
module nio_seq
  import nio_pkg::*;
#(
  parameter int SETTLE_CYC = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         hold_i,
  input  logic                         run_i,
  input  nib_t                         cmd_i,
  input  nib_t                         arg_a_i,
  input  nib_t                         arg_b_i,
  input  logic [SUM_W-1:0]             sum_i,
  input  logic [NPORT-1:0][NIB_W-1:0]  in_i,
  output logic [DEPTH-1:0]             eng_we_o,
  output logic [DEPTH-1:0][NIB_W-1:0]  eng_wdata_o,
  output nib_t                         out_a_o,
  output nib_t                         out_b_o,
  output logic                         cfg_load_o,
  output logic                         busy_o,
  output logic                         done_o
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_RLD = CNT_W'(SETTLE_CYC - 1);

  seq_st_t          st_q, st_d;
  nib_t             cmd_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  nib_t             oa_d, ob_d;
  logic             fin;

  always_comb begin
    st_d        = st_q;
    cnt_d       = cnt_q;
    oa_d        = out_a_o;
    ob_d        = out_b_o;
    fin         = 1'b0;
    cfg_load_o  = 1'b0;
    eng_we_o    = '0;
    eng_wdata_o = '0;
    if (hold_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (run_i) st_d = ST_EXEC;
        ST_EXEC: begin
          case (cmd_q)
            CMD_READ_SW: begin
              for (int p = 0; p < NPORT; p++) begin
                eng_we_o[p]    = 1'b1;
                eng_wdata_o[p] = ~in_i[p];
              end
              oa_d = arg_a_i;
              ob_d = arg_b_i;
              fin  = 1'b1;
            end
            CMD_COIN_CFG: begin
              cfg_load_o = 1'b1;
              fin        = 1'b1;
            end
            CMD_PATTERN: begin
              eng_we_o[PAT_ADR_LO]    = 1'b1;
              eng_wdata_o[PAT_ADR_LO] = PAT_LO;
              eng_we_o[PAT_ADR_HI]    = 1'b1;
              eng_wdata_o[PAT_ADR_HI] = PAT_HI;
              fin = 1'b1;
            end
            CMD_CHKSUM: begin
              eng_we_o[0]    = 1'b1;
              eng_wdata_o[0] = sum_i[SUM_W-1:NIB_W];
              eng_we_o[1]    = 1'b1;
              eng_wdata_o[1] = sum_i[NIB_W-1:0];
              fin = 1'b1;
            end
            CMD_SCAN2: begin
              oa_d  = '0;
              cnt_d = CNT_RLD;
              st_d  = ST_SC0;
            end
            default: fin = 1'b1;
          endcase
        end
        ST_SC0: begin
          if (cnt_q == '0) begin
            for (int p = 0; p < NPORT; p++) begin
              eng_we_o[2*p]    = 1'b1;
              eng_wdata_o[2*p] = ~in_i[p];
            end
            oa_d  = NIB_W'(1);
            cnt_d = CNT_RLD;
            st_d  = ST_SC1;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        ST_SC1: begin
          if (cnt_q == '0) begin
            for (int p = 0; p < NPORT; p++) begin
              eng_we_o[2*p+1]    = 1'b1;
              eng_wdata_o[2*p+1] = ~in_i[p];
            end
            fin = 1'b1;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
      if (fin) st_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cmd_q   <= '0;
      cnt_q   <= '0;
      out_a_o <= '0;
      out_b_o <= '0;
      done_o  <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      out_a_o <= oa_d;
      out_b_o <= ob_d;
      done_o  <= fin;
      if (st_q == ST_IDLE && run_i && !hold_i) cmd_q <= cmd_i;
    end
  end

  assign busy_o = (st_q != ST_IDLE);
endmodule

// File: rtl/nibble_io_ctrl.sv
module nibble_io_ctrl
  import nio_pkg::*;
#(
  parameter int SETTLE_CYC = 2,
  parameter int COIN_DEF   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  output logic              hold_stat_o,
  input  logic              host_we_i,
  input  logic [3:0]        host_addr_i,
  input  logic [7:0]        host_wdata_i,
  output logic [7:0]        host_rdata_o,
  input  logic              run_i,
  output logic              busy_o,
  output logic              done_o,
  input  logic [3:0]        in_a_i,
  input  logic [3:0]        in_b_i,
  input  logic [3:0]        in_c_i,
  input  logic [3:0]        in_d_i,
  output logic [3:0]        out_a_o,
  output logic [3:0]        out_b_o,
  output logic [3:0]        cfg_coins0_o,
  output logic [3:0]        cfg_creds0_o,
  output logic [3:0]        cfg_coins1_o,
  output logic [3:0]        cfg_creds1_o
);
  logic [DEPTH-1:0][NIB_W-1:0] mem_q;
  logic [DEPTH-1:0]            eng_we;
  logic [DEPTH-1:0][NIB_W-1:0] eng_wdata;
  logic [NPORT-1:0][NIB_W-1:0] in_pk;
  logic [SUM_W-1:0]            sum;
  logic                        cfg_load;
  coin_cfg_t                   cfg_ld, cfg_q;
  logic                        unused_hi;

  assign unused_hi = ^host_wdata_i[HOST_W-1:NIB_W];
  assign in_pk     = {in_d_i, in_c_i, in_b_i, in_a_i};

  nio_ram u_ram (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_we_i    (host_we_i),
    .host_addr_i  (host_addr_i),
    .host_wdata_i (host_wdata_i[NIB_W-1:0]),
    .eng_we_i     (eng_we),
    .eng_wdata_i  (eng_wdata),
    .mem_o        (mem_q)
  );

  nio_chksum u_sum (
    .arg_i (mem_q[DEPTH-1:ADR_ARG]),
    .sum_o (sum)
  );

  nio_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hold_i      (hold_i),
    .run_i       (run_i),
    .cmd_i       (mem_q[ADR_CMD]),
    .arg_a_i     (mem_q[ADR_ARG]),
    .arg_b_i     (mem_q[ADR_ARG+1]),
    .sum_i       (sum),
    .in_i        (in_pk),
    .eng_we_o    (eng_we),
    .eng_wdata_o (eng_wdata),
    .out_a_o     (out_a_o),
    .out_b_o     (out_b_o),
    .cfg_load_o  (cfg_load),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  assign cfg_ld = '{coins0: mem_q[ADR_ARG],   creds0: mem_q[ADR_ARG+1],
                    coins1: mem_q[ADR_ARG+2], creds1: mem_q[ADR_ARG+3]};

  nio_coin_cfg #(.COIN_DEF(COIN_DEF)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (hold_i),
    .load_i (cfg_load),
    .cfg_i  (cfg_ld),
    .cfg_o  (cfg_q)
  );

  assign cfg_coins0_o = cfg_q.coins0;
  assign cfg_creds0_o = cfg_q.creds0;
  assign cfg_coins1_o = cfg_q.coins1;
  assign cfg_creds1_o = cfg_q.creds1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_stat_o <= 1'b0;
    else         hold_stat_o <= hold_i;
  end

  assign host_rdata_o = {{(HOST_W-NIB_W){1'b1}}, mem_q[host_addr_i]};
endmodule

// File: rtl/nibble_io_ctrl_chk.sv
module nibble_io_ctrl_chk
  import nio_pkg::*;
#(
  parameter int SETTLE_CYC = 2,
  parameter int COIN_DEF   = 1
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        hold_i,
  input logic                        hold_stat_o,
  input logic                        host_we_i,
  input logic [3:0]                  host_addr_i,
  input logic [7:0]                  host_wdata_i,
  input logic                        busy_o,
  input logic                        done_o,
  input logic [3:0]                  out_a_o,
  input logic [3:0]                  cfg_coins0_o,
  input logic [3:0]                  cfg_creds0_o,
  input logic [3:0]                  cfg_coins1_o,
  input logic [3:0]                  cfg_creds1_o,
  input logic [DEPTH-1:0][NIB_W-1:0] mem_i,
  input logic [DEPTH-1:0]            eng_we_i
);
  localparam logic [3:0] DEF = 4'(COIN_DEF);

  logic [3:0] prev_oa_q;
  logic [7:0] since_q;
  logic       scan_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_oa_q <= '0;
      since_q   <= '0;
    end else begin
      prev_oa_q <= out_a_o;
      if (out_a_o != prev_oa_q) since_q <= '0;
      else if (since_q != 8'hFF) since_q <= since_q + 8'd1;
    end
  end

  assign scan_wr = (eng_we_i[0] && eng_we_i[2] && !eng_we_i[1]) ||
                   (eng_we_i[1] && eng_we_i[3] && !eng_we_i[0]);

  AST_HOST_WR_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && !eng_we_i[host_addr_i]) |=>
      mem_i[$past(host_addr_i)] == $past(host_wdata_i[3:0])); // R2

  AST_ENG_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|eng_we_i) |-> busy_o); // R3

  AST_IDLE_RAM_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !host_we_i) |=> $stable(mem_i)); // R10

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11

  AST_DONE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && !$past(hold_i)) |-> done_o); // R11

  AST_HOLD_DEFAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (cfg_coins0_o == DEF && cfg_creds0_o == DEF &&
                cfg_coins1_o == DEF && cfg_creds1_o == DEF)); // R12

  AST_HOLD_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> hold_stat_o); // R12

  AST_SCAN_SETTLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_wr |-> (out_a_o == prev_oa_q && 32'(since_q) >= SETTLE_CYC - 2)); // R8
endmodule

bind nibble_io_ctrl nibble_io_ctrl_chk #(
  .SETTLE_CYC(SETTLE_CYC),
  .COIN_DEF  (COIN_DEF)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .hold_i       (hold_i),
  .hold_stat_o  (hold_stat_o),
  .host_we_i    (host_we_i),
  .host_addr_i  (host_addr_i),
  .host_wdata_i (host_wdata_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .out_a_o      (out_a_o),
  .cfg_coins0_o (cfg_coins0_o),
  .cfg_creds0_o (cfg_creds0_o),
  .cfg_coins1_o (cfg_coins1_o),
  .cfg_creds1_o (cfg_creds1_o),
  .mem_i        (mem_q),
  .eng_we_i     (eng_we)
);

// File: tb/nibble_io_ctrl_tb.sv
`timescale 1ns/1ps
module nibble_io_ctrl_tb;
  localparam int SETTLE = 2;
  localparam int NV     = 10;
  localparam int WD_LIMIT = 50000;
  // {cmd, nib9..nib15, ports-phase0 A..D, ports-phase1 A..D}
  localparam logic [63:0] VEC [NV] = '{
    64'h1_3C00000_1234_1234,
    64'h1_A500000_F0A5_F0A5,
    64'h8_1234567_0000_0000,
    64'h8_FFFFFFF_0000_0000,
    64'h9_0000000_1357_8ACE,
    64'h9_1111111_FFFF_0000,
    64'h2_3254000_0000_0000,
    64'h7_0000000_0000_0000,
    64'h3_ABCDEF1_0000_0000,
    64'hF_0000000_0000_0000
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, hold_i = 1'b0, run_i = 1'b0;
  logic host_we_i = 1'b0;
  logic [3:0] host_addr_i = '0;
  logic [7:0] host_wdata_i = '0;
  logic hold_stat_o, busy_o, done_o;
  logic [7:0] host_rdata_o;
  logic [3:0] in_a_i, in_b_i, in_c_i, in_d_i, out_a_o, out_b_o;
  logic [3:0] cfg_coins0_o, cfg_creds0_o, cfg_coins1_o, cfg_creds1_o;

  logic [15:0] set0_r = '0, set1_r = '0;
  logic        sel_q;
  logic [3:0]  bm [16];
  logic [3:0]  exp_oa = '0, exp_ob = '0;
  logic [3:0]  exp_cfg [4];
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit ended = 1'b0;

  always #2.5 clk_i = ~clk_i;

  nibble_io_ctrl #(.SETTLE_CYC(SETTLE), .COIN_DEF(1)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold_i), .hold_stat_o(hold_stat_o),
    .host_we_i(host_we_i), .host_addr_i(host_addr_i), .host_wdata_i(host_wdata_i),
    .host_rdata_o(host_rdata_o), .run_i(run_i), .busy_o(busy_o), .done_o(done_o),
    .in_a_i(in_a_i), .in_b_i(in_b_i), .in_c_i(in_c_i), .in_d_i(in_d_i),
    .out_a_o(out_a_o), .out_b_o(out_b_o),
    .cfg_coins0_o(cfg_coins0_o), .cfg_creds0_o(cfg_creds0_o),
    .cfg_coins1_o(cfg_coins1_o), .cfg_creds1_o(cfg_creds1_o)
  );

  // external multiplexer: selector lags out_a bit 0 by one register
  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sel_q <= 1'b0; else sel_q <= out_a_o[0];
  assign in_a_i = sel_q ? set1_r[15:12] : set0_r[15:12];
  assign in_b_i = sel_q ? set1_r[11:8]  : set0_r[11:8];
  assign in_c_i = sel_q ? set1_r[7:4]   : set0_r[7:4];
  assign in_d_i = sel_q ? set1_r[3:0]   : set0_r[3:0];

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT && !ended) begin
      ended = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input int a, input logic [7:0] d);
    @(negedge clk_i);
    host_we_i = 1'b1; host_addr_i = 4'(a); host_wdata_i = d;
    @(negedge clk_i);
    host_we_i = 1'b0;
    bm[a] = d[3:0];
  endtask

  task automatic check_ram(input string tag);
    for (int i = 0; i < 16; i++) begin
      host_addr_i = 4'(i);
      #1;
      chk($sformatf("%s nibble %0d", tag, i), int'(host_rdata_o), int'({4'hF, bm[i]}));
    end
  endtask

  task automatic check_outs(input string tag);
    chk({tag, " out_a"}, int'(out_a_o), int'(exp_oa));
    chk({tag, " out_b"}, int'(out_b_o), int'(exp_ob));
    chk({tag, " cfg"}, int'({cfg_coins0_o, cfg_creds0_o, cfg_coins1_o, cfg_creds1_o}),
        int'({exp_cfg[0], exp_cfg[1], exp_cfg[2], exp_cfg[3]}));
  endtask

  task automatic run_cmd(output int lat);
    @(negedge clk_i); run_i = 1'b1;
    @(negedge clk_i); run_i = 1'b0;
    chk("R3 busy after capture", int'(busy_o), 1);
    lat = 0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk_i);
      if (done_o) begin lat = k; break; end
    end
  endtask

  task automatic apply_vec(input logic [63:0] v);
    logic [3:0] cmd, arg [7];
    int lat, lat_e, s;
    string tag;
    cmd = v[63:60];
    for (int j = 0; j < 7; j++) arg[j] = v[59-4*j -: 4];
    for (int i = 0; i < 8; i++) host_wr(i, 8'hA0 | 8'((i * 3 + int'(cmd)) & 15));
    host_wr(8, {4'h5, cmd});
    for (int j = 0; j < 7; j++) host_wr(9 + j, {4'hC, arg[j]});
    set0_r = v[31:16]; set1_r = v[15:0];
    lat_e = 1;
    case (cmd)
      4'd1: begin
        tag = "R4 cmd1";
        for (int p = 0; p < 4; p++) bm[p] = ~set0_r[15-4*p -: 4];
        exp_oa = arg[0]; exp_ob = arg[1];
      end
      4'd2: begin
        tag = "R5 cmd2";
        for (int j = 0; j < 4; j++) exp_cfg[j] = arg[j];
      end
      4'd7: begin
        tag = "R9 cmd7";
        bm[2] = 4'hE; bm[7] = 4'h6;
      end
      4'd8: begin
        tag = "R6 cmd8";
        s = 0;
        for (int j = 0; j < 7; j++) s += int'(arg[j]);
        bm[0] = 4'(s >> 4); bm[1] = 4'(s);
      end
      4'd9: begin
        tag = "R7 R8 cmd9";
        for (int p = 0; p < 4; p++) begin
          bm[2*p]   = ~set0_r[15-4*p -: 4];
          bm[2*p+1] = ~set1_r[15-4*p -: 4];
        end
        exp_oa = 4'h1;
        lat_e = 1 + 2 * SETTLE;
      end
      default: tag = "R10 unknown";
    endcase
    run_cmd(lat);
    chk({"R11 done latency ", tag}, lat, lat_e);
    check_ram(tag);
    check_outs(tag);
  endtask

  initial begin
    int lat, dones;
    logic [7:0] d;
    for (int i = 0; i < 16; i++) bm[i] = '0;
    for (int j = 0; j < 4; j++) exp_cfg[j] = 4'h1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // reset state
    check_ram("R1 reset");
    check_outs("R1 reset");
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 hold_stat", int'(hold_stat_o), 0);

    // host path: only low nibble stored, upper forced
    host_wr(12, 8'h5A);
    host_addr_i = 4'd12; #1;
    chk("R2 read-back", int'(host_rdata_o), 'hFA);

    for (int v = 0; v < NV; v++) apply_vec(VEC[v]);

    // engine beats host on same nibble and edge
    host_wr(2, 8'h00);
    host_wr(8, 8'h07);
    @(negedge clk_i); run_i = 1'b1;
    @(negedge clk_i); run_i = 1'b0;
    host_we_i = 1'b1; host_addr_i = 4'd2; host_wdata_i = 8'h03;
    @(negedge clk_i); host_we_i = 1'b0;
    bm[2] = 4'hE; bm[7] = 4'h6;
    host_addr_i = 4'd2; #1;
    chk("R13 engine priority", int'(host_rdata_o), 'hFE);

    // run while busy is ignored
    host_wr(8, 8'h09);
    host_wr(10, 8'h06);
    @(negedge clk_i); run_i = 1'b1;
    @(negedge clk_i); run_i = 1'b0;
    dones = 0;
    for (int k = 1; k <= 14; k++) begin
      @(negedge clk_i);
      if (k == 2) run_i = 1'b1;
      if (k == 3) run_i = 1'b0;
      if (done_o) dones++;
    end
    chk("R3 single done for run while busy", dones, 1);
    chk("R3 idle afterwards", int'(busy_o), 0);
    chk("R3 out_b unchanged", int'(out_b_o), int'(exp_ob));

    // hold line
    @(negedge clk_i); hold_i = 1'b1;
    @(negedge clk_i);
    chk("R12 hold_stat", int'(hold_stat_o), 1);
    chk("R12 cfg defaults", int'({cfg_coins0_o, cfg_creds0_o, cfg_coins1_o, cfg_creds1_o}), 'h1111);
    host_wr(8, 8'h07);
    host_wr(2, 8'h09);
    host_wr(7, 8'h09);
    @(negedge clk_i); run_i = 1'b1;
    @(negedge clk_i); run_i = 1'b0;
    chk("R12 busy held off", int'(busy_o), 0);
    repeat (3) @(negedge clk_i);
    chk("R12 no done", int'(done_o), 0);
    host_addr_i = 4'd2; #1;
    chk("R12 nibble 2 untouched", int'(host_rdata_o), 'hF9);
    host_addr_i = 4'd7; #1;
    chk("R12 nibble 7 untouched", int'(host_rdata_o), 'hF9);
    hold_i = 1'b0;
    @(negedge clk_i);
    chk("R12 hold_stat released", int'(hold_stat_o), 0);

    // asynchronous reset mid-run
    host_wr(8, 8'h09);
    @(negedge clk_i); run_i = 1'b1;
    @(negedge clk_i); run_i = 1'b0;
    #1 rst_ni = 1'b0;
    #1;
    host_addr_i = 4'd9; #1;
    d = host_rdata_o;
    chk("R1 async clear", int'(d), 'hF0);
    chk("R1 async busy", int'(busy_o), 0);
    chk("R1 async out_a", int'(out_a_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;

    ended = 1'b1;
    summary();
    $finish;
  end
endmodule